// File: doc/BRIEF.md
# Match Aging Bitmap

This block records which forwarding-table entries have been hit since software last looked. The block keeps one sticky bit per entry. Each match reported by the lookup side sets the bit chosen by the entry index. Software sweeps the table periodically. It reads each 32-bit word and then writes back a mask of ones to clear the bits it has counted.

A second 32-bit word with the same behaviour covers the 32 entries of the collision memory. A separate hit input feeds it. The two bit stores are updated together in every cycle.

The central property is that no hit is ever lost. When a hit and a software clear land on the same word in the same cycle, the clear is applied first and the hit second. A hit that races a clear therefore still shows up in the next sweep.

Top module: `hit_bitmap_tracker`

## Requirements
- R1: After a synchronous active-low reset every bit of the main bitmap and of the collision word is 0, and `bus_rvalid` and `bus_rdata` are 0.
- R2: A cycle with `hit_valid` high sets one bit of the main bitmap. The word is chosen by `hit_index[12:5]` and the bit within that word by `hit_index[4:0]`. Any read issued after that clock edge returns the bit as 1.
- R3: A bit that is set stays at 1 until software clears it. Repeated hits and hits to other bits do not change it.
- R4: A bus write to main word `bus_addr[7:0]` (with `bus_addr[8]`=0) clears the bits where `bus_wdata` is 1. Bits where `bus_wdata` is 0 keep their value, and all other words keep their value.
- R5: If a hit and a clear target the same bit in the same cycle, the bit is 1 afterwards.
- R6: If a hit and a clear target different bits of the same word in the same cycle, both take effect.
- R7: A read presented with `bus_rd` high is answered one cycle later. `bus_rvalid` is then 1, and `bus_rdata` holds the word as it stood before the clock edge that accepted the read.
- R8: The collision word is selected by `bus_addr[8]`=1, with the low address bits ignored. It is set by `aux_hit_valid` at bit `aux_hit_index[4:0]` and cleared by a write-1-to-clear. If a hit and a clear target the same bit in the same cycle, the set wins.
- R9: Main hits and writes do not change the collision word. Collision hits and writes do not change the main bitmap.
- R10: `bus_rvalid` is 0 in every cycle that does not follow a cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | Main table match event |
| hit_index | input | 13 | Matched main entry: word in [12:5], bit in [4:0] |
| aux_hit_valid | input | 1 | Collision memory match event |
| aux_hit_index | input | 5 | Matched collision entry |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write-1-to-clear request |
| bus_addr | input | 9 | [8]=1 selects the collision word, otherwise [7:0] selects a main word |
| bus_wdata | input | 32 | Clear mask |
| bus_rdata | output | 32 | Read word, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer strobe, one cycle after bus_rd |

## Verification
The bench targets the clear/hit races, in which a hit and a clear land in the same cycle. A wrong merge order or a whole-word overwrite would drop the hit in those cases and read back 0 where the expected value is 1. It also targets the edges of the index range: bit 0 of word 0 and bit 31 of word 255. A slicing error there would set a neighbouring word or bit. A read issued in the same cycle as a hit to the same word must return the old value, and its answer must arrive exactly one cycle later. The bench also checks that an all-ones clear of a main word leaves the collision word untouched. A decoder that ignores the address select bit would wipe it.

// File: rtl/hb_pkg.sv
// Package: shared word type for the match aging bitmap.
// Assumes: the bus word and the collision register are both 32 bits wide.
package hb_pkg;
    localparam int BUS_W = 32;
    typedef logic [BUS_W-1:0] word_t;
endpackage

// File: rtl/hb_merge.sv
// Module: hb_merge
// Computes the next value of one bitmap word from its current value, a clear
// mask and an optional single-bit set. The clear is applied first and the set
// second, so a hit that races a clear always survives.
// Assumes: at most one set bit per cycle per word.
module hb_merge #(
    parameter int W  = 32,
    localparam int BW = $clog2(W)
) (
    input  logic [W-1:0]  cur_word,
    input  logic          set_en,
    input  logic [BW-1:0] set_bit,
    input  logic          clr_en,
    input  logic [W-1:0]  clr_mask,
    output logic [W-1:0]  nxt_word
);
    logic [W-1:0] kept;
    logic [W-1:0] set_mask;

    // Apply the clear first, then OR in the single hit bit (set wins).
    always_comb begin
        kept     = cur_word & ~({W{clr_en}} & clr_mask);
        set_mask = {{(W-1){1'b0}}, set_en} << set_bit;
        nxt_word = kept | set_mask;
    end
endmodule

// File: rtl/hb_store.sv
// Module: hb_store
// Flop-based bitmap of DEPTH words of W bits. In every cycle it takes one
// single-bit set (by word and bit) and one word-wide clear mask, and it offers
// a combinational read of one word.
// Assumes: DEPTH >= 2 and is a power of two; synchronous active-low reset.
module hb_store #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_word,
    input  logic [BW-1:0] set_bit,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_word,
    input  logic [W-1:0]  clr_mask,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);
    logic [DEPTH-1:0][W-1:0] words_flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic         set_here;
        logic         clr_here;
        logic [W-1:0] nxt;
        logic [W-1:0] word_q;

        // Decode whether this word is the target of the set or the clear.
        assign set_here = set_en && (set_word == IW'(g));
        assign clr_here = clr_en && (clr_word == IW'(g));

        hb_merge #(.W(W)) merge_i (
            .cur_word (word_q),
            .set_en   (set_here),
            .set_bit  (set_bit),
            .clr_en   (clr_here),
            .clr_mask (clr_mask),
            .nxt_word (nxt)
        );

        // Word register, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= nxt;
        end

        assign words_flat[g] = word_q;
    end

    assign rd_word = words_flat[rd_idx];

    // Checker state: remembers last cycle's set and clean clear.
    logic          chk_set_v_q;
    logic [IW-1:0] chk_set_w_q;
    logic [BW-1:0] chk_set_b_q;
    logic          chk_clr_v_q;
    logic [IW-1:0] chk_clr_w_q;
    logic [W-1:0]  chk_clr_m_q;

    // Capture events so the following cycle can verify their effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_set_v_q <= 1'b0;
            chk_set_w_q <= '0;
            chk_set_b_q <= '0;
            chk_clr_v_q <= 1'b0;
            chk_clr_w_q <= '0;
            chk_clr_m_q <= '0;
        end else begin
            chk_set_v_q <= set_en;
            chk_set_w_q <= set_word;
            chk_set_b_q <= set_bit;
            chk_clr_v_q <= clr_en && !(set_en && set_word == clr_word);
            chk_clr_w_q <= clr_word;
            chk_clr_m_q <= clr_mask;
        end
    end

    AST_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_set_v_q |-> words_flat[chk_set_w_q][chk_set_b_q]); // R2 R5

    AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_clr_v_q |-> ((words_flat[chk_clr_w_q] & chk_clr_m_q) == '0)); // R4
endmodule

// File: rtl/hb_aux_reg.sv
// Module: hb_aux_reg
// A single W-bit sticky hit register for the collision memory entries, with
// the same set-wins write-1-to-clear behaviour as the main bitmap.
// Assumes: synchronous active-low reset.
module hb_aux_reg #(
    parameter int W  = 32,
    localparam int BW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [BW-1:0] set_bit,
    input  logic          clr_en,
    input  logic [W-1:0]  clr_mask,
    output logic [W-1:0]  word
);
    logic [W-1:0] nxt;
    logic [W-1:0] word_q;

    hb_merge #(.W(W)) merge_i (
        .cur_word (word_q),
        .set_en   (set_en),
        .set_bit  (set_bit),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .nxt_word (nxt)
    );

    // Collision hit register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= nxt;
    end

    assign word = word_q;

    logic          chk_v_q;
    logic [BW-1:0] chk_b_q;

    // Remember last cycle's hit for the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_v_q <= 1'b0;
            chk_b_q <= '0;
        end else begin
            chk_v_q <= set_en;
            chk_b_q <= set_bit;
        end
    end

    AST_AUX_HIT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v_q |-> word_q[chk_b_q]); // R8
endmodule

// File: rtl/hit_bitmap_tracker.sv
// Module: hit_bitmap_tracker (top)
// Sticky per-entry match bitmap with a word-wide bus port. Lookup hits set
// bits; software reads words (one-cycle latency) and clears them with
// write-1-to-clear. A separate collision word sits at bus_addr MSB = 1.
// Assumes: ENTRIES is a multiple of the 32-bit bus word; synchronous
// active-low reset; a read returns the value before that edge's updates.
module hit_bitmap_tracker
    import hb_pkg::*;
#(
    parameter int ENTRIES = 8192,
    localparam int WORDS  = ENTRIES / BUS_W,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIT_W  = $clog2(BUS_W),
    localparam int IDX_W  = WIDX_W + BIT_W,
    localparam int ADDR_W = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    input  logic [IDX_W-1:0]  hit_index,
    input  logic              aux_hit_valid,
    input  logic [BIT_W-1:0]  aux_hit_index,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid
);
    logic              sel_aux;
    logic [WIDX_W-1:0] word_sel;
    word_t             main_word;
    word_t             aux_word;
    word_t             rdata_q;
    logic              rvalid_q;

    assign sel_aux  = bus_addr[ADDR_W-1];
    assign word_sel = bus_addr[WIDX_W-1:0];

    hb_store #(.DEPTH(WORDS), .W(BUS_W)) main_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (hit_valid),
        .set_word (hit_index[IDX_W-1:BIT_W]),
        .set_bit  (hit_index[BIT_W-1:0]),
        .clr_en   (bus_wr && !sel_aux),
        .clr_word (word_sel),
        .clr_mask (bus_wdata),
        .rd_idx   (word_sel),
        .rd_word  (main_word)
    );

    hb_aux_reg #(.W(BUS_W)) aux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (aux_hit_valid),
        .set_bit  (aux_hit_index),
        .clr_en   (bus_wr && sel_aux),
        .clr_mask (bus_wdata),
        .word     (aux_word)
    );

    // Registered read path: capture the selected word one cycle after bus_rd.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= sel_aux ? aux_word : main_word;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!bus_rvalid && bus_rdata == '0)); // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R7

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid); // R10

    AST_AUX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_hit_valid && !(bus_wr && sel_aux)) |=> $stable(aux_word)); // R9
endmodule

// File: tb/hit_bitmap_tracker_tb_top.sv
`timescale 1ns/1ps
module hit_bitmap_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic [12:0] hit_index = '0;
    logic        aux_hit_valid = 1'b0;
    logic [4:0]  aux_hit_index = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hit_bitmap_tracker dut_i (
        .clk, .rst_n, .hit_valid, .hit_index, .aux_hit_valid, .aux_hit_index,
        .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .bus_rvalid
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 hit, 1 clear, 2 read-and-compare
        logic [8:0]  addr;
        logic [12:0] idx;
        logic [31:0] data;  // clear mask or expected word
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 9'd0,   13'h0000, 32'h0},
        '{2'd0, 9'd0,   13'h001F, 32'h0},
        '{2'd2, 9'd0,   13'h0000, 32'h8000_0001},
        '{2'd0, 9'd0,   13'h1FFF, 32'h0},
        '{2'd0, 9'd0,   13'h0025, 32'h0},
        '{2'd2, 9'd255, 13'h0000, 32'h8000_0000},
        '{2'd2, 9'd1,   13'h0000, 32'h0000_0020},
        '{2'd0, 9'd0,   13'h0000, 32'h0},
        '{2'd2, 9'd0,   13'h0000, 32'h8000_0001},
        '{2'd1, 9'd0,   13'h0000, 32'h0000_0001},
        '{2'd2, 9'd0,   13'h0000, 32'h8000_0000},
        '{2'd1, 9'd1,   13'h0000, 32'h0000_0000},
        '{2'd2, 9'd1,   13'h0000, 32'h0000_0020},
        '{2'd2, 9'd2,   13'h0000, 32'h0000_0000},
        '{2'd2, 9'd256, 13'h0000, 32'h0000_0000},
        '{2'd1, 9'd255, 13'h0000, 32'hFFFF_FFFF},
        '{2'd2, 9'd255, 13'h0000, 32'h0000_0000}
    };

    // One clock of stimulus, driven at a falling edge and released at the next.
    task automatic step(input logic hv, input logic [12:0] hi,
                        input logic av, input logic [4:0] ai,
                        input logic wr, input logic rd,
                        input logic [8:0] a, input logic [31:0] wd);
        @(negedge clk);
        hit_valid = hv; hit_index = hi; aux_hit_valid = av; aux_hit_index = ai;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        hit_valid = 1'b0; aux_hit_valid = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Read a word and compare; also confirm the strobe arrived.
    task automatic read_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, a, '0);
        check({req, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        read_chk("R1 word0", 9'd0, 32'd0);
        read_chk("R1 word255", 9'd255, 32'd0);
        read_chk("R1 aux", 9'd256, 32'd0);

        // Table walk: R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: step(1'b1, VECS[i].idx, 1'b0, '0, 1'b0, 1'b0, '0, '0);
                2'd1: step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, VECS[i].addr, VECS[i].data);
                default: read_chk($sformatf("R2/R3/R4/R9 vec %0d", i), VECS[i].addr, VECS[i].data);
            endcase
        end

        // R10: idle cycle has no strobe
        @(negedge clk);
        check("R10 idle", {31'd0, bus_rvalid}, 32'd0);

        // R7: read racing a hit on the same word returns the old value
        step(1'b1, 13'h0060, 1'b0, '0, 1'b0, 1'b1, 9'd3, '0);
        check("R7 old value", bus_rdata, 32'd0);
        check("R7 rvalid", {31'd0, bus_rvalid}, 32'd1);
        read_chk("R7 new value", 9'd3, 32'h0000_0001);

        // R5: hit and clear on the same bit, same cycle
        step(1'b1, 13'h0041, 1'b0, '0, 1'b1, 1'b0, 9'd2, 32'hFFFF_FFFF);
        read_chk("R5 set wins", 9'd2, 32'h0000_0002);
        // R6: hit and clear on different bits of one word
        step(1'b1, 13'h0042, 1'b0, '0, 1'b1, 1'b0, 9'd2, 32'h0000_0002);
        read_chk("R6 both apply", 9'd2, 32'h0000_0004);

        // R8: collision word set, clear, race
        step(1'b0, '0, 1'b1, 5'd7, 1'b0, 1'b0, '0, '0);
        read_chk("R8 aux set", 9'd256, 32'h0000_0080);
        step(1'b0, '0, 1'b1, 5'd3, 1'b1, 1'b0, 9'd256, 32'h0000_0088);
        read_chk("R8 aux race", 9'd256, 32'h0000_0008);

        // R9: all-ones main clear leaves collision word; collision hits leave main
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 9'd0, 32'hFFFF_FFFF);
        read_chk("R9 aux kept", 9'd256, 32'h0000_0008);
        read_chk("R9 main word0 cleared", 9'd0, 32'h0000_0000);
        read_chk("R9 main word4 untouched", 9'd4, 32'h0000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule